// File: doc/BRIEF.md
# Two-Strike Watchdog Timer

This block is a watchdog countdown timer with a small register file behind a single-cycle register write port and a combinational read port. Software loads an initial tick count and clears the halt bit to arm the timer. It then rewrites the reload register at regular intervals to keep the timer from running out. The count drops by one on each cycle in which the external tick-enable input is high.

When the count runs out the first time, the block only raises a status flag and, if enabled, a one-cycle SMI request, and then restarts. If it runs out a second time in a row, it records that in its second status register and pulses a system-reset request. Two inputs can block that reset: a board strap and a no-reboot control. A blocked second expiry behaves like a first one. The data-in and data-out registers have side effects when written, which give software a way to raise an SMI or an interrupt flag itself.

Registers are selected by a 4-bit register number (see R10). Reads return the selected register, zero-extended to 16 bits.

Top module: `twostrike_wdt`

## Requirements
- R1: After reset the initial-value register (number 10) reads 4, control register 2 (number 6) reads 0x0008, the IRQ-generation byte (number 11) reads 0x03, every other register reads 0, and the timer is stopped.
- R2: The timer starts only when the halt bit (bit 11 of control register 1, number 5) is clear and the initial-value register holds more than 1. A start loads the count (reload register, number 0, bits 9:0) from the initial value.
- R3: While running, the count drops by one on each cycle with tick_en high, and it holds on every other cycle. Reading the reload register returns the live count.
- R4: On an expiry (a tick while the count is 1 or less) the timeout flag (bit 3 of status register 1, number 3) is set. If no reset is requested, smi_req pulses only when smi_tco_en is high, and the count reloads from the initial value.
- R5: On the second consecutive expiry, bits 1 and 2 of status register 2 (number 4) are set. If strap_hi and no_reboot are both low, sys_reset_req pulses, the count reads 0, the timer stops, and no SMI is raised.
- R6: If strap_hi or no_reboot is high, a second expiry raises no reset and the timer keeps running. The strike count returns to zero, so the next reset needs two more expiries.
- R7: A write to the reload register clears the strike count. If start conditions hold, the count restarts from the initial value. Otherwise the written word is stored as is and the timer stays stopped.
- R8: The lock bit (bit 12 of control register 1) cannot be cleared by a write once it is set; only reset clears it. A write to control register 1 restarts the timer if start conditions hold and stops it otherwise.
- R9: A write to data-in (number 1) stores its low byte, sets bit 1 of status register 1, and pulses smi_req. A write to data-out (number 2) stores its low byte and sets bit 2 of status register 1.
- R10: Writes are masked so that only the writable bits are stored:
  - status register 1: 0x000E
  - status register 2: 0x0006
  - control register 1: 0x1800
  - control register 2: 0x000F
  - initial value: 0x03FF
  - message bytes (7, 8), watchdog-count byte (9) and IRQ-generation byte (11): 0x00FF
- R11: A tick in a cycle with a bus write is dropped. smi_req and sys_reset_req are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle countdown tick |
| strap_hi | input | 1 | Strap that blocks the reset action when high |
| no_reboot | input | 1 | Control that blocks the reset action when high |
| smi_tco_en | input | 1 | Enables SMI requests on expiry |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register number |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| smi_req | output | 1 | SMI request pulse |
| sys_reset_req | output | 1 | System reset request pulse |

## Verification
The hardest state to reach from the ports is the second consecutive expiry, because the strike count is invisible and survives restarts from control register 1. The stimulus counts exact ticks through two full periods with a short initial value. It repeats the sequence with each blocking input raised, and again with a reload write between the two expiries, so that the strike count is shown to be cleared.

// File: rtl/twostrike_wdt.sv
module twostrike_wdt #(
  parameter int CW = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        strap_hi,
  input  logic        no_reboot,
  input  logic        smi_tco_en,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        smi_req,
  output logic        sys_reset_req
);

  localparam logic [3:0] A_RLD = 4'd0, A_DIN = 4'd1, A_DOUT = 4'd2, A_ST1 = 4'd3,
                         A_ST2 = 4'd4, A_CT1 = 4'd5, A_CT2 = 4'd6, A_MS1 = 4'd7,
                         A_MS2 = 4'd8, A_WDC = 4'd9, A_TMR = 4'd10, A_IRQ = 4'd11;
  localparam logic [15:0] M_ST1 = 16'h000E, M_ST2 = 16'h0006,
                          M_CT1 = 16'h1800, M_CT2 = 16'h000F;
  localparam int HALT = 11, LOCK = 12;
  localparam int B_SWSMI = 1, B_INT = 2, B_TO = 3;
  localparam logic [15:0] STRIKE2 = 16'h0006;
  localparam int PADW = 16 - CW;

  logic [15:0] rld, sts1, sts2, ctrl1, ctrl2;
  logic [CW-1:0] tmr;
  logic [7:0]  din, dout, msg1, msg2, wdcnt, irqg;
  logic        running, strike, smi_q, rst_q;

  wire [15:0] tmr16    = {{PADW{1'b0}}, tmr};
  wire        tmr_ok   = tmr > CW'(1);
  wire        can_run  = !ctrl1[HALT] && tmr_ok;
  wire [15:0] ctrl1_nx = (bus_wdata & M_CT1) | (ctrl1 & (16'h1 << LOCK));
  wire        boot     = strike && !strap_hi && !no_reboot;

  assign smi_req       = smi_q;
  assign sys_reset_req = rst_q;

  always_comb begin
    case (bus_addr)
      A_RLD:   bus_rdata = rld;
      A_DIN:   bus_rdata = {8'h0, din};
      A_DOUT:  bus_rdata = {8'h0, dout};
      A_ST1:   bus_rdata = sts1;
      A_ST2:   bus_rdata = sts2;
      A_CT1:   bus_rdata = ctrl1;
      A_CT2:   bus_rdata = ctrl2;
      A_MS1:   bus_rdata = {8'h0, msg1};
      A_MS2:   bus_rdata = {8'h0, msg2};
      A_WDC:   bus_rdata = {8'h0, wdcnt};
      A_TMR:   bus_rdata = tmr16;
      A_IRQ:   bus_rdata = {8'h0, irqg};
      default: bus_rdata = 16'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rld <= '0; sts1 <= '0; sts2 <= '0; ctrl1 <= '0; ctrl2 <= 16'h0008;
      tmr <= CW'(4); din <= '0; dout <= '0; msg1 <= '0; msg2 <= '0;
      wdcnt <= '0; irqg <= 8'h03; running <= 1'b0; strike <= 1'b0;
      smi_q <= 1'b0; rst_q <= 1'b0;
    end else begin
      smi_q <= 1'b0;
      rst_q <= 1'b0;
      if (bus_wr) begin
        case (bus_addr)
          A_RLD: begin
            strike <= 1'b0;
            if (can_run) begin
              rld <= tmr16;
              running <= 1'b1;
            end else begin
              rld <= bus_wdata;
            end
          end
          A_DIN: begin
            din <= bus_wdata[7:0];
            sts1[B_SWSMI] <= 1'b1;
            smi_q <= 1'b1;
          end
          A_DOUT: begin
            dout <= bus_wdata[7:0];
            sts1[B_INT] <= 1'b1;
          end
          A_ST1: sts1 <= bus_wdata & M_ST1;
          A_ST2: sts2 <= bus_wdata & M_ST2;
          A_CT1: begin
            ctrl1 <= ctrl1_nx;
            if (!ctrl1_nx[HALT] && tmr_ok) begin
              rld <= tmr16;
              running <= 1'b1;
            end else begin
              running <= 1'b0;
            end
          end
          A_CT2: ctrl2 <= bus_wdata & M_CT2;
          A_MS1: msg1 <= bus_wdata[7:0];
          A_MS2: msg2 <= bus_wdata[7:0];
          A_WDC: wdcnt <= bus_wdata[7:0];
          A_TMR: tmr <= bus_wdata[CW-1:0];
          A_IRQ: irqg <= bus_wdata[7:0];
          default: ;
        endcase
      end else if (running && tick_en) begin
        if (rld[CW-1:0] > CW'(1)) begin
          rld[CW-1:0] <= rld[CW-1:0] - CW'(1);
        end else begin
          sts1[B_TO] <= 1'b1;
          strike <= !strike;
          if (strike) sts2 <= sts2 | STRIKE2;
          if (boot) begin
            rst_q <= 1'b1;
            running <= 1'b0;
            rld <= '0;
          end else begin
            smi_q <= smi_tco_en;
            rld <= tmr16;
          end
        end
      end
    end
  end

  a_r5_reset_stops: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |-> (!running && rld == 16'h0));
  a_r5_reset_flags: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |-> ((sts2 & STRIKE2) == STRIKE2));
  a_r6_reset_gated: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |-> $past(!strap_hi && !no_reboot));
  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctrl1[LOCK]) |-> ctrl1[LOCK]);
  a_r2_halt_stops: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> !ctrl1[HALT]);
  a_r11_reset_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |=> !sys_reset_req);

endmodule

// File: tb/sim_twostrike_wdt.sv
`timescale 1ns/1ps
module sim_twostrike_wdt;
  localparam logic [3:0] RLD = 4'd0, DIN = 4'd1, DOUT = 4'd2, ST1 = 4'd3, ST2 = 4'd4,
                         CT1 = 4'd5, CT2 = 4'd6, MS1 = 4'd7, MS2 = 4'd8, WDC = 4'd9,
                         TMR = 4'd10, IRQ = 4'd11;
  localparam int NV = 10;
  localparam logic [35:0] TBL [NV] = '{
    36'h7_01A5_00A5, 36'h8_FF3C_003C, 36'h9_0177_0077, 36'hB_0F0F_000F,
    36'h3_FFFF_000E, 36'h4_FFFF_0006, 36'h6_FFFF_000F, 36'hA_FFFF_03FF,
    36'h5_FFFF_1800, 36'h5_0000_1000};

  logic clk = 0, rst_n = 0, tick_en = 0, strap_hi = 0, no_reboot = 0, smi_tco_en = 0;
  logic bus_wr = 0;
  logic [3:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic smi_req, sys_reset_req;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  twostrike_wdt u0 (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .strap_hi(strap_hi),
    .no_reboot(no_reboot), .smi_tco_en(smi_tco_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .smi_req(smi_req),
    .sys_reset_req(sys_reset_req));

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    #0.2;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_en = 1;
      @(negedge clk);
      tick_en = 0;
    end
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R10 / R8: masked write table
    for (int i = 0; i < NV; i++) begin
      wr(TBL[i][35:32], TBL[i][31:16]);
      rd(TBL[i][35:32], TBL[i][15:0], "R10 mask table");
    end
    wr(CT1, 16'h0000);
    rd(CT1, 16'h1000, "R8 lock stays set");

    do_reset();
    // R1: reset values; R8 lock cleared by reset
    rd(TMR, 16'h0004, "R1 init value");
    rd(CT2, 16'h0008, "R1 ctrl2");
    rd(IRQ, 16'h0003, "R1 irq byte");
    rd(RLD, 16'h0000, "R1 reload");
    rd(ST1, 16'h0000, "R1 status1");
    rd(CT1, 16'h0000, "R8 reset clears lock");
    tick(6);
    chk("R1 stopped after reset", {15'h0, smi_req | sys_reset_req}, 16'h0);
    rd(RLD, 16'h0000, "R1 no count");

    // R2: value 1 never starts
    wr(TMR, 16'h0001);
    wr(CT1, 16'h0000);
    rd(RLD, 16'h0000, "R2 tmr=1 no start");
    wr(TMR, 16'h0003);
    wr(CT1, 16'h0800);
    rd(RLD, 16'h0000, "R2 halt no start");
    wr(CT1, 16'h0000);
    rd(RLD, 16'h0003, "R2 start loads count");

    // R3: countdown on ticks only
    tick(1);
    rd(RLD, 16'h0002, "R3 one tick");
    repeat (4) @(negedge clk);
    rd(RLD, 16'h0002, "R3 hold without tick");
    smi_tco_en = 1;
    tick(2);
    chk("R4 first expiry smi", {15'h0, smi_req}, 16'h1);
    chk("R4 no reset on first", {15'h0, sys_reset_req}, 16'h0);
    rd(ST1, 16'h0008, "R4 timeout flag");
    rd(RLD, 16'h0003, "R4 reload");

    // R5: second expiry resets
    tick(3);
    chk("R5 reset pulse", {15'h0, sys_reset_req}, 16'h1);
    chk("R5 no smi on reset", {15'h0, smi_req}, 16'h0);
    @(negedge clk);
    chk("R11 reset single cycle", {15'h0, sys_reset_req}, 16'h0);
    rd(ST2, 16'h0006, "R5 second flags");
    rd(RLD, 16'h0000, "R5 count zero");
    tick(4);
    rd(RLD, 16'h0000, "R5 stopped");

    // R6: blocked by no_reboot, then by strap
    wr(ST2, 16'h0000);
    no_reboot = 1;
    wr(CT1, 16'h0000);
    tick(6);
    chk("R6 no_reboot blocks", {15'h0, sys_reset_req}, 16'h0);
    chk("R6 smi instead", {15'h0, smi_req}, 16'h1);
    rd(ST2, 16'h0006, "R6 flags still set");
    rd(RLD, 16'h0003, "R6 keeps running");
    no_reboot = 0; strap_hi = 1;
    tick(6);
    chk("R6 strap blocks", {15'h0, sys_reset_req}, 16'h0);
    strap_hi = 0;

    // R7: reload write clears strike; R4 smi disabled
    smi_tco_en = 0;
    tick(3);
    chk("R4 smi disabled", {15'h0, smi_req}, 16'h0);
    wr(RLD, 16'h0055);
    rd(RLD, 16'h0003, "R7 restart from init");
    tick(3);
    chk("R7 strike cleared", {15'h0, sys_reset_req}, 16'h0);
    tick(3);
    chk("R7 second after reload", {15'h0, sys_reset_req}, 16'h1);
    wr(CT1, 16'h0800);
    wr(RLD, 16'h1234);
    tick(2);
    rd(RLD, 16'h1234, "R7 stored when halted");

    // R9: data ports
    wr(ST1, 16'h0000);
    wr(DIN, 16'h035A);
    chk("R9 data-in smi", {15'h0, smi_req}, 16'h1);
    rd(ST1, 16'h0002, "R9 sw smi flag");
    rd(DIN, 16'h005A, "R9 data-in value");
    wr(DOUT, 16'h00C3);
    rd(ST1, 16'h0006, "R9 int flag");
    rd(DOUT, 16'h00C3, "R9 data-out value");

    // R11: tick with write dropped
    wr(CT1, 16'h0000);
    @(negedge clk);
    bus_wr = 1; bus_addr = MS1; bus_wdata = 16'h0011; tick_en = 1;
    @(negedge clk);
    bus_wr = 0; tick_en = 0;
    rd(RLD, 16'h0003, "R11 tick dropped on write");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule